// File: doc/BRIEF.md
# Max-Min Fair Share Allocator

This block divides one shared capacity among a fixed set of requesters so that the result is max-min fair. Each requester states a demand. Requesters that ask for little get everything they ask for. The capacity they leave unused is spread evenly over the requesters that still want more. The process repeats in passes until nobody unsatisfied remains or the equal share left to hand out truncates to zero.

All quantities are 16-bit unsigned fixed point with 8 fractional bits. A client places the capacity and the demand vector on the inputs and pulses `start`. The block copies them and runs its passes. Each pass divides the remaining capacity by the number of unsatisfied requesters with a bit-serial divider. It then raises `done` and holds the allocation vector steady until the next `start`. A zero demand marks an unused slot.

Top module: `mmf_alloc`

## Requirements
- R1: A requester whose demand is zero is not counted as active and receives an allocation of zero. When every demand is zero, all allocations are zero.
- R2: No allocation ever exceeds the demand of its requester.
- R3: The sum of all allocations never exceeds the captured capacity. Truncation residue from the division stays unallocated.
- R4: When the sum of all demands is at most the capacity, every requester receives exactly its demand.
- R5: The first pass offers each active requester floor(capacity / number of active requesters). If every active demand exceeds that offer, each active requester ends with exactly that offer.
- R6: In each pass, every unsatisfied requester whose remaining need fits within the current equal share is satisfied first. The capacity left over is then re-divided among the rest. Example: capacity 0x0A00 and demands 0x0200, 0x0299, 0x0400, 0x0500 give 0x0200, 0x0299, 0x02B3, 0x02B3.
- R7: The procedure stops as soon as the equal share of the remaining capacity truncates to zero. Requesters that are still unsatisfied keep what they already have.
- R8: `done` is low from the cycle after `start` is accepted until the result is ready. It then stays high, with the allocations stable, until the next `start`. A `start` that arrives while a computation runs is ignored.
- R9: After reset, `done` is low and every allocation is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to capture inputs and begin a computation |
| capacity | input | 16 | Shared capacity, unsigned 8.8 fixed point |
| demand_flat | input | 64 | Four demands, requester i in bits [16i+15:16i] |
| alloc_flat | output | 64 | Four allocations, same packing as the demands |
| done | output | 1 | High while a finished result is held |

## Verification
The assertions assume the inputs matter only in the cycle where `start` is taken, and that `start` may arrive at any time, including during a computation. The bench changes capacity and demands only on the falling edge. It deliberately drives a second `start` with different data while the block is busy, and changes the inputs without `start` after completion. The properties on bounded allocations and on total capacity are stated against the captured copies, so input activity between runs cannot disturb them.

// File: rtl/mmf_pkg.sv
package mmf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PASS,
        ST_WAIT,
        ST_APPLY,
        ST_DONE
    } mmf_state_e;
endpackage

// File: rtl/mmf_div.sv
module mmf_div #(
    parameter int W  = 16,
    parameter int DW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  dividend,
    input  logic [DW-1:0] divisor,
    output logic [W-1:0]  quotient,
    output logic          valid
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic          vld;
        logic [CW-1:0] cnt;
        logic [W-1:0]  quo;
        logic [DW-1:0] rem;
        logic [DW-1:0] dvs;
        logic [W-1:0]  dvd;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [DW:0] rem_sh;
    logic [DW:0] diff;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        rem_sh   = {st_q.rem, st_q.quo[W-1]};
        diff     = rem_sh - {1'b0, st_q.dvs};
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(W);
            st_d.quo  = dividend;
            st_d.rem  = '0;
            st_d.dvs  = divisor;
            st_d.dvd  = dividend;
        end else if (st_q.busy) begin
            if (rem_sh >= {1'b0, st_q.dvs}) begin
                st_d.rem = diff[DW-1:0];
                st_d.quo = {st_q.quo[W-2:0], 1'b1};
            end else begin
                st_d.rem = rem_sh[DW-1:0];
                st_d.quo = {st_q.quo[W-2:0], 1'b0};
            end
            st_d.cnt = st_q.cnt - CW'(1);
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.vld  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign quotient = st_q.quo;
    assign valid    = st_q.vld;

    AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((W+DW)'(st_q.quo) * (W+DW)'(st_q.dvs) <= (W+DW)'(st_q.dvd)) &&
                  ((W+DW)'(st_q.quo) * (W+DW)'(st_q.dvs) + (W+DW)'(st_q.dvs) > (W+DW)'(st_q.dvd))); // R5
endmodule

// File: rtl/mmf_lane.sv
module mmf_lane #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] dem,
    input  logic [W-1:0] alloc,
    input  logic         active,
    input  logic [W-1:0] share,
    output logic [W-1:0] need,
    output logic         fits
);
    assign need = dem - alloc;
    assign fits = active && (need <= share);

    AST_ALLOC_LE_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
        alloc <= dem); // R2
    AST_ZERO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (dem == '0) |-> (alloc == '0) && !active); // R1
endmodule

// File: rtl/mmf_alloc.sv
module mmf_alloc #(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   capacity,
    input  logic [N*W-1:0] demand_flat,
    output logic [N*W-1:0] alloc_flat,
    output logic           done
);
    import mmf_pkg::*;

    localparam int LW = $clog2(N + 1);
    localparam int SW = W + LW;

    typedef struct packed {
        mmf_state_e          st;
        logic [N-1:0]        act;
        logic [N-1:0][W-1:0] dem;
        logic [N-1:0][W-1:0] alloc;
        logic [W-1:0]        cap;
        logic [W-1:0]        rem;
        logic [W-1:0]        share;
    } top_state_t;

    top_state_t q_q, q_d;

    logic [N-1:0][W-1:0] need;
    logic [N-1:0]        fits;
    logic [LW-1:0]       act_cnt;
    logic                div_start;
    logic [W-1:0]        div_quo;
    logic                div_valid;

    always_comb begin
        act_cnt = '0;
        for (int i = 0; i < N; i++) act_cnt = act_cnt + LW'(q_q.act[i]);
    end

    for (genvar g = 0; g < N; g++) begin : g_lane
        mmf_lane #(.W(W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .dem    (q_q.dem[g]),
            .alloc  (q_q.alloc[g]),
            .active (q_q.act[g]),
            .share  (q_q.share),
            .need   (need[g]),
            .fits   (fits[g])
        );
    end

    mmf_div #(.W(W), .DW(LW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (q_q.rem),
        .divisor  (act_cnt),
        .quotient (div_quo),
        .valid    (div_valid)
    );

    always_comb begin
        q_d       = q_q;
        div_start = 1'b0;
        unique case (q_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    q_d.st    = ST_PASS;
                    q_d.dem   = demand_flat;
                    q_d.alloc = '0;
                    q_d.cap   = capacity;
                    q_d.rem   = capacity;
                    q_d.share = '0;
                    for (int i = 0; i < N; i++)
                        q_d.act[i] = (demand_flat[i*W +: W] != '0);
                end
            end
            ST_PASS: begin
                if (q_q.act == '0) begin
                    q_d.st = ST_DONE;
                end else begin
                    div_start = 1'b1;
                    q_d.st    = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (div_valid) begin
                    if (div_quo == '0) begin
                        q_d.st = ST_DONE;
                    end else begin
                        q_d.share = div_quo;
                        q_d.st    = ST_APPLY;
                    end
                end
            end
            ST_APPLY: begin
                if (|fits) begin
                    for (int i = 0; i < N; i++) begin
                        if (fits[i]) begin
                            q_d.alloc[i] = q_q.alloc[i] + need[i];
                            q_d.act[i]   = 1'b0;
                            q_d.rem      = q_d.rem - need[i];
                        end
                    end
                    q_d.st = ST_PASS;
                end else begin
                    for (int i = 0; i < N; i++) begin
                        if (q_q.act[i]) begin
                            q_d.alloc[i] = q_q.alloc[i] + q_q.share;
                            q_d.act[i]   = 1'b0;
                            q_d.rem      = q_d.rem - q_q.share;
                        end
                    end
                    q_d.st = ST_DONE;
                end
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign alloc_flat = q_q.alloc;
    assign done       = (q_q.st == ST_DONE);

    logic [SW-1:0] alloc_sum;
    logic [SW-1:0] dem_sum;
    always_comb begin
        alloc_sum = '0;
        dem_sum   = '0;
        for (int i = 0; i < N; i++) begin
            alloc_sum = alloc_sum + SW'(q_q.alloc[i]);
            dem_sum   = dem_sum + SW'(q_q.dem[i]);
        end
    end

    AST_TOTAL_LE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_sum <= SW'(q_q.cap)); // R3
    AST_ALL_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dem_sum <= SW'(q_q.cap)) |-> (q_q.alloc == q_q.dem)); // R4
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(alloc_flat)); // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st != ST_IDLE && q_q.st != ST_DONE) |=> $stable(q_q.dem) && $stable(q_q.cap)); // R8
endmodule

// File: tb/mmf_alloc_bench.sv
module mmf_alloc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int W  = 16;
    localparam int NV = 9;

    typedef logic [W-1:0] val_t;

    localparam val_t VCAP [NV] = '{16'h0A00, 16'h0A00, 16'h1000, 16'h03E8, 16'h0002,
                                   16'h0100, 16'h0600, 16'h0400, 16'h0000};
    localparam val_t VDEM [NV][N] = '{
        '{16'h0200, 16'h0299, 16'h0400, 16'h0500},
        '{16'h0500, 16'h0500, 16'h0500, 16'h0500},
        '{16'h0100, 16'h0200, 16'h0300, 16'h0400},
        '{16'h0000, 16'h0400, 16'h0400, 16'h0400},
        '{16'h0100, 16'h0100, 16'h0100, 16'h0100},
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h0800, 16'h0100, 16'h0080, 16'h0400},
        '{16'h0100, 16'h0100, 16'h0100, 16'h0100},
        '{16'h0300, 16'h0001, 16'h0000, 16'h0200}};
    localparam val_t VEXP [NV][N] = '{
        '{16'h0200, 16'h0299, 16'h02B3, 16'h02B3},
        '{16'h0280, 16'h0280, 16'h0280, 16'h0280},
        '{16'h0100, 16'h0200, 16'h0300, 16'h0400},
        '{16'h0000, 16'h014D, 16'h014D, 16'h014D},
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h0240, 16'h0100, 16'h0080, 16'h0240},
        '{16'h0100, 16'h0100, 16'h0100, 16'h0100},
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000}};
    localparam string VREQ [NV] = '{"R6", "R5", "R4", "R1", "R7", "R1", "R6", "R4", "R7"};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   capacity = '0;
    logic [N*W-1:0] demand_flat = '0;
    logic [N*W-1:0] alloc_flat;
    logic           done;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmf_alloc #(.N(N), .W(W)) u_mmf_alloc (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .capacity    (capacity),
        .demand_flat (demand_flat),
        .alloc_flat  (alloc_flat),
        .done        (done)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    task automatic load(input int v);
        capacity = VCAP[v];
        for (int i = 0; i < N; i++) demand_flat[i*W +: W] = VDEM[v][i];
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(req, int'(done), 1);
    endtask

    function automatic int lane(input int i);
        return int'(alloc_flat[i*W +: W]);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL R8 watchdog expired actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", int'(done), 0);
        check("R9", int'(alloc_flat != '0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", int'(done), 0);

        for (int v = 0; v < NV; v++) begin
            int total;
            load(v);
            pulse_start();
            wait_done(VREQ[v]);
            total = 0;
            for (int i = 0; i < N; i++) begin
                check(VREQ[v], lane(i), int'(VEXP[v][i]));
                check("R2", int'(lane(i) <= int'(VDEM[v][i])), 1);
                total += lane(i);
            end
            check("R3", int'(total <= int'(VCAP[v])), 1);
        end

        // R8: done falls after start, and a start while busy is ignored
        load(0);
        pulse_start();
        check("R8", int'(done), 0);
        load(1);
        pulse_start();
        check("R8", int'(done), 0);
        wait_done("R8");
        for (int i = 0; i < N; i++) check("R8", lane(i), int'(VEXP[0][i]));

        // R8: input changes without start leave the held result untouched
        load(6);
        repeat (5) @(negedge clk);
        check("R8", int'(done), 1);
        for (int i = 0; i < N; i++) check("R8", lane(i), int'(VEXP[0][i]));

        // R8: a new start from the done state is accepted
        pulse_start();
        check("R8", int'(done), 0);
        wait_done("R8");
        for (int i = 0; i < N; i++) check("R6", lane(i), int'(VEXP[6][i]));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule